// File: doc/BRIEF.md
# SPI Target Port with Length-Capped Buffers

This block is the target (slave) side of a full-duplex SPI link. An external master opens a transaction by driving the active-low select low and closes it by releasing the select. On every serial clock pulse in between, one bit arrives on MOSI and one bit leaves on MISO. Received bits go into a 512-bit receive buffer. Transmitted bits come from a 512-bit transmit buffer, which the local side loads while the bus is idle. The master alone decides how many pulses it sends. A programmed length caps how many of those bits are stored or sent, and when the select is released the block reports the number of bits it actually moved.

All serial inputs are brought into the system clock through two-flop synchronisers, and every edge is detected in the system-clock domain. The system clock must therefore run at least four times faster than the serial clock. Clock polarity and phase come from a 2-bit mode code. Bit order is chosen separately for receive and for transmit. An optional early-launch setting moves the MISO update forward by half a serial period in the phase-0 modes. Either direction can be switched off.

Top module: `spi_target`

## Requirements
- R1: `cfg_mode` selects polarity and phase as {CPOL, CPHA} = cfg_mode[1:0]. The leading edge is rising when CPOL=0 and falling when CPOL=1. MOSI is sampled on the leading edge when CPHA=0 and on the trailing edge when CPHA=1.
- R2: Received bit number k (counted from 0) is stored in byte k/8 of `rx_data`, at bit position k%8 when `cfg_rx_lsb`=1 and at position 7-k%8 when it is 0. When receive is enabled, a transaction first clears the whole receive buffer, so positions not written in that transaction read 0.
- R3: Transmit bit number k is taken from byte k/8 of the loaded buffer, at position k%8 when `cfg_tx_lsb`=1 and at position 7-k%8 when it is 0. With CPHA=0, bit 0 appears when the select asserts and each later bit appears after a trailing edge. With CPHA=1, each bit appears after its leading edge.
- R4: The effective length is `cfg_len`, with any value above 512 treated as 512. Bits at positions at or beyond the effective length are neither stored nor sent, and MISO carries 0 for them.
- R5: `trans_len` reports the smaller of the number of sampling edges the master clocked and the effective length. It holds that value until the next transaction completes.
- R6: After the select is released, `done` pulses high for exactly one cycle. The pulse comes three system-clock edges after the release, and `trans_len` is valid in that cycle.
- R7: With `cfg_rx_en`=0, a transaction leaves `rx_data` entirely unchanged.
- R8: With `cfg_tx_en`=0, MISO stays 0 for the whole transaction.
- R9: With `cfg_early`=1 and CPHA=0, the next MISO bit is launched at the leading edge, so it is already on the line before the trailing edge. With CPHA=1, `cfg_early` has no effect.
- R10: `tx_load` copies `tx_data` into the transmit buffer only while the synchronised select is deasserted. A load attempted during a transaction is ignored.
- R11: While the select is deasserted, `miso_oe_o` is 0 and `miso_o` is 0. While it is asserted, `miso_oe_o` is 1.
- R12: After reset, `done` is 0, `trans_len` is 0, `rx_data` is 0 and MISO is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the master |
| cs_n_i | input | 1 | Active-low select from the master |
| mosi_i | input | 1 | Serial data from the master |
| miso_o | output | 1 | Serial data to the master |
| miso_oe_o | output | 1 | Output enable for the MISO pad |
| cfg_mode | input | 2 | {CPOL, CPHA} |
| cfg_early | input | 1 | Early MISO launch for CPHA=0 modes |
| cfg_rx_lsb | input | 1 | Receive least significant bit first |
| cfg_tx_lsb | input | 1 | Transmit least significant bit first |
| cfg_rx_en | input | 1 | Receive path enable |
| cfg_tx_en | input | 1 | Transmit path enable |
| cfg_len | input | 10 | Maximum bits stored or sent |
| tx_load | input | 1 | Load strobe for the transmit buffer |
| tx_data | input | 512 | Transmit buffer contents |
| rx_data | output | 512 | Receive buffer contents |
| trans_len | output | 10 | Bits transferred in the last transaction |
| done | output | 1 | One-cycle end-of-transaction pulse |

## Verification
Each serial input passes through two synchroniser flops before the edge logic acts on it, and a third register stage holds the result. MISO, the receive buffer and `done` therefore move three system-clock edges after the pin that caused them. The bench holds each serial half-period for eight system clocks. It reads MISO at the master's sampling edge, just before toggling the clock. It reads the mid-phase MISO value six cycles after the leading edge, which is after any launch has settled and before the trailing edge. After releasing the select, it watches a twelve-cycle window and counts `done` pulses there, then checks `rx_data`, `trans_len` and the idle state of MISO.

// File: rtl/spit_pkg.sv
package spit_pkg;

  typedef struct packed {
    logic cpol;
    logic cpha;
  } clk_mode_t;

  function automatic clk_mode_t decode_mode(input logic [1:0] code);
    clk_mode_t r;
    r.cpol = code[1];
    r.cpha = code[0];
    return r;
  endfunction

  // position of serial bit k inside its byte
  function automatic logic [2:0] lane(input logic [2:0] k, input logic lsb_first);
    return lsb_first ? k : ~k;
  endfunction

endpackage

// File: rtl/spit_sync.sv
module spit_sync #(
  parameter int unsigned   W       = 1,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_d
);

  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
      q_d  <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
      q_d  <= q;
    end
  end

endmodule

// File: rtl/spit_phase.sv
module spit_phase
  import spit_pkg::*;
(
  input  clk_mode_t mode,
  input  logic      early,
  input  logic      sclk_s,
  input  logic      sclk_d,
  input  logic      cs_n_s,
  input  logic      cs_n_d,
  output logic      active,
  output logic      open_ev,
  output logic      close_ev,
  output logic      sample_ev,
  output logic      launch_ev
);

  logic rise, fall, lead, trail, launch_on_lead;

  always_comb begin
    rise           = sclk_s & ~sclk_d;
    fall           = ~sclk_s & sclk_d;
    lead           = mode.cpol ? fall : rise;
    trail          = mode.cpol ? rise : fall;
    launch_on_lead = mode.cpha | early;
    active         = ~cs_n_s;
    open_ev        = cs_n_d & ~cs_n_s;
    close_ev       = ~cs_n_d & cs_n_s;
    sample_ev      = active & ~open_ev & (mode.cpha ? trail : lead);
    launch_ev      = active & ~open_ev & (launch_on_lead ? lead : trail);
  end

endmodule

// File: rtl/spit_rx.sv
module spit_rx
  import spit_pkg::*;
#(
  parameter int unsigned BUF_BITS = 512,
  localparam int unsigned LEN_W   = $clog2(BUF_BITS) + 1,
  localparam int unsigned IDX_W   = $clog2(BUF_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                active,
  input  logic                open_ev,
  input  logic                close_ev,
  input  logic                sample_ev,
  input  logic                mosi,
  input  logic                rx_en,
  input  logic                rx_lsb,
  input  logic [LEN_W-1:0]    len_eff,
  output logic [BUF_BITS-1:0] rx_data,
  output logic [LEN_W-1:0]    trans_len,
  output logic                done
);

  logic [LEN_W-1:0]    cnt_q, cnt_n;
  logic [BUF_BITS-1:0] buf_q, buf_n;
  logic [LEN_W-1:0]    tlen_q, tlen_n;
  logic                done_q, done_n;
  logic                room;
  logic [IDX_W-1:0]    slot;

  always_comb begin
    room   = cnt_q < len_eff;
    slot   = {cnt_q[IDX_W-1:3], lane(cnt_q[2:0], rx_lsb)};
    cnt_n  = cnt_q;
    buf_n  = buf_q;
    tlen_n = tlen_q;
    done_n = 1'b0;
    if (open_ev) begin
      cnt_n = '0;
      if (rx_en) buf_n = '0;
    end else if (sample_ev && room) begin
      cnt_n = cnt_q + 1'b1;
      if (rx_en) buf_n[slot] = mosi;
    end
    if (close_ev) begin
      done_n = 1'b1;
      tlen_n = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      buf_q  <= '0;
      tlen_q <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      buf_q  <= buf_n;
      tlen_q <= tlen_n;
      done_q <= done_n;
    end
  end

  assign rx_data   = buf_q;
  assign trans_len = tlen_q;
  assign done      = done_q;

  // R6: the completion pulse never lasts two cycles
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R5: a reported length never exceeds the buffer size
  a_r5_len_capped: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (tlen_q <= LEN_W'(BUF_BITS)));

  // R4: the bit counter stays within the effective length during a transaction
  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> (cnt_q <= len_eff));

  // R7: with receive off, the buffer does not move
  a_r7_rx_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && $past(!rx_en)) |-> $stable(buf_q));

endmodule

// File: rtl/spit_tx.sv
module spit_tx
  import spit_pkg::*;
#(
  parameter int unsigned BUF_BITS = 512,
  localparam int unsigned LEN_W   = $clog2(BUF_BITS) + 1,
  localparam int unsigned IDX_W   = $clog2(BUF_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_idle,
  input  logic                open_ev,
  input  logic                close_ev,
  input  logic                launch_ev,
  input  logic                cpha,
  input  logic                tx_en,
  input  logic                tx_lsb,
  input  logic [LEN_W-1:0]    len_eff,
  input  logic                tx_load,
  input  logic [BUF_BITS-1:0] tx_data,
  output logic                miso
);

  logic [BUF_BITS-1:0] buf_q, buf_n;
  logic [LEN_W-1:0]    lcnt_q, lcnt_n;
  logic                miso_q, miso_n;
  logic                cur_bit, first_bit;
  logic [IDX_W-1:0]    slot_cur, slot_first;

  always_comb begin
    slot_cur   = {lcnt_q[IDX_W-1:3], lane(lcnt_q[2:0], tx_lsb)};
    slot_first = {{(IDX_W-3){1'b0}}, lane(3'd0, tx_lsb)};
    cur_bit    = tx_en && (lcnt_q < len_eff) && buf_q[slot_cur];
    first_bit  = tx_en && (len_eff != '0) && buf_q[slot_first];
  end

  always_comb begin
    buf_n  = buf_q;
    lcnt_n = lcnt_q;
    miso_n = miso_q;
    if (tx_load && cs_idle) buf_n = tx_data;
    if (open_ev) begin
      if (cpha) begin
        miso_n = 1'b0;
        lcnt_n = '0;
      end else begin
        miso_n = first_bit;
        lcnt_n = LEN_W'(1);
      end
    end else if (launch_ev) begin
      miso_n = cur_bit;
      if (lcnt_q < len_eff) lcnt_n = lcnt_q + 1'b1;
    end
    if (close_ev) miso_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      lcnt_q <= '0;
      miso_q <= 1'b0;
    end else begin
      buf_q  <= buf_n;
      lcnt_q <= lcnt_n;
      miso_q <= miso_n;
    end
  end

  assign miso = miso_q;

  // R10: the transmit buffer is frozen while the select stays asserted
  a_r10_buf_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_idle && $past(!cs_idle)) |-> $stable(buf_q));

  // R8: with transmit off, nothing but 0 is launched
  a_r8_tx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && $past(!tx_en) && $past(!tx_en, 2)) |-> !miso_q);

endmodule

// File: rtl/spi_target.sv
module spi_target
  import spit_pkg::*;
#(
  parameter int unsigned BUF_BITS = 512,
  localparam int unsigned LEN_W   = $clog2(BUF_BITS) + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sclk_i,
  input  logic                cs_n_i,
  input  logic                mosi_i,
  output logic                miso_o,
  output logic                miso_oe_o,
  input  logic [1:0]          cfg_mode,
  input  logic                cfg_early,
  input  logic                cfg_rx_lsb,
  input  logic                cfg_tx_lsb,
  input  logic                cfg_rx_en,
  input  logic                cfg_tx_en,
  input  logic [LEN_W-1:0]    cfg_len,
  input  logic                tx_load,
  input  logic [BUF_BITS-1:0] tx_data,
  output logic [BUF_BITS-1:0] rx_data,
  output logic [LEN_W-1:0]    trans_len,
  output logic                done
);

  // reset: asynchronous assert, synchronous release
  logic rst_meta, rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_core_n <= rst_meta;
    end
  end

  logic [2:0] pins_s, pins_d;
  spit_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d     ({mosi_i, cs_n_i, sclk_i}),
    .q     (pins_s),
    .q_d   (pins_d)
  );

  clk_mode_t        mode;
  logic [LEN_W-1:0] len_eff;
  logic             active, open_ev, close_ev, sample_ev, launch_ev;
  logic             miso_raw;

  always_comb begin
    mode    = decode_mode(cfg_mode);
    len_eff = (cfg_len > LEN_W'(BUF_BITS)) ? LEN_W'(BUF_BITS) : cfg_len;
  end

  spit_phase u_phase (
    .mode      (mode),
    .early     (cfg_early),
    .sclk_s    (pins_s[0]),
    .sclk_d    (pins_d[0]),
    .cs_n_s    (pins_s[1]),
    .cs_n_d    (pins_d[1]),
    .active    (active),
    .open_ev   (open_ev),
    .close_ev  (close_ev),
    .sample_ev (sample_ev),
    .launch_ev (launch_ev)
  );

  spit_rx #(.BUF_BITS(BUF_BITS)) u_rx (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .active    (active),
    .open_ev   (open_ev),
    .close_ev  (close_ev),
    .sample_ev (sample_ev),
    .mosi      (pins_s[2]),
    .rx_en     (cfg_rx_en),
    .rx_lsb    (cfg_rx_lsb),
    .len_eff   (len_eff),
    .rx_data   (rx_data),
    .trans_len (trans_len),
    .done      (done)
  );

  spit_tx #(.BUF_BITS(BUF_BITS)) u_tx (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .cs_idle   (pins_s[1]),
    .open_ev   (open_ev),
    .close_ev  (close_ev),
    .launch_ev (launch_ev),
    .cpha      (mode.cpha),
    .tx_en     (cfg_tx_en),
    .tx_lsb    (cfg_tx_lsb),
    .len_eff   (len_eff),
    .tx_load   (tx_load),
    .tx_data   (tx_data),
    .miso      (miso_raw)
  );

  assign miso_oe_o = active;
  assign miso_o    = active & miso_raw;

  // R11: completion is only signalled once the pad is released
  a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_core_n)
    done |-> !miso_oe_o);

  // R11: an idle pad carries no data
  a_r11_idle_low: assert property (@(posedge clk) disable iff (!rst_core_n)
    !miso_oe_o |-> !miso_o);

  // R6: a completion pulse follows a cycle in which the select was active
  a_r6_done_after_active: assert property (@(posedge clk) disable iff (!rst_core_n)
    done |-> $past(active, 2));

endmodule

// File: tb/spi_target_test.sv
module spi_target_test;

  localparam int BB = 512;
  localparam int LW = 10;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sclk, cs_n, mosi;
  logic          miso, miso_oe;
  logic [1:0]    mode;
  logic          early, rx_lsb, tx_lsb, rx_en, tx_en;
  logic [LW-1:0] len;
  logic          tx_load;
  logic [BB-1:0] tx_data, rx_data;
  logic [LW-1:0] trans_len;
  logic          done;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [BB-1:0] tx_vec;   // what the bench believes is loaded
  logic [BB-1:0] mvec;     // master's MOSI pattern

  always #4 clk = ~clk;

  spi_target uut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .cs_n_i(cs_n), .mosi_i(mosi),
    .miso_o(miso), .miso_oe_o(miso_oe), .cfg_mode(mode), .cfg_early(early),
    .cfg_rx_lsb(rx_lsb), .cfg_tx_lsb(tx_lsb), .cfg_rx_en(rx_en), .cfg_tx_en(tx_en),
    .cfg_len(len), .tx_load(tx_load), .tx_data(tx_data), .rx_data(rx_data),
    .trans_len(trans_len), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input logic [BB-1:0] act, input logic [BB-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int eff_len();
    return (int'(len) > BB) ? BB : int'(len);
  endfunction

  function automatic int slot(input int k, input logic lsb);
    int p = k % 8;
    return (k / 8) * 8 + (lsb ? p : 7 - p);
  endfunction

  function automatic logic exp_tx(input int k);
    if (!tx_en || k >= eff_len()) return 1'b0;
    return tx_vec[slot(k, tx_lsb)];
  endfunction

  function automatic logic mbit(input int k);
    return mvec[k % BB];
  endfunction

  task automatic load_tx(input logic [BB-1:0] v);
    @(negedge clk);
    tx_data = v;
    tx_load = 1'b1;
    @(negedge clk);
    tx_load = 1'b0;
    tx_vec  = v;
  endtask

  task automatic set_pattern(input int seed);
    for (int w = 0; w < BB / 32; w++) begin
      mvec[w*32 +: 32] = 32'h9E37_79B9 * (seed + w + 1) ^ 32'h5A3C_96E1;
    end
  endtask

  // one master transaction of n clock pulses; poke_at >= 0 tries a load mid-way
  task automatic xfer(input int n, input int poke_at, input string tag);
    logic          cpol, cpha;
    logic [BB-1:0] exp_rx, prev_rx;
    int            bad_s, bad_m, dcnt, nexp;
    logic [LW-1:0] tl;
    bit            oe_seen;
    cpol = mode[1];
    cpha = mode[0];
    bad_s = 0; bad_m = 0; dcnt = 0; tl = '0; oe_seen = 1'b1;
    @(negedge clk);
    sclk = cpol;
    repeat (6) @(negedge clk);
    prev_rx = rx_data;
    cs_n = 1'b0;
    if (!cpha) mosi = mbit(0);
    repeat (8) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      if (k == poke_at) begin
        tx_data = ~tx_vec;
        tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
      end
      if (!miso_oe) oe_seen = 1'b0;
      if (!cpha) begin
        if (miso !== exp_tx(k)) bad_s++;
        sclk = ~sclk;
        repeat (6) @(negedge clk);
        if (miso !== (early ? exp_tx(k + 1) : exp_tx(k))) bad_m++;
        repeat (2) @(negedge clk);
        sclk = ~sclk;
        mosi = mbit(k + 1);
        repeat (8) @(negedge clk);
      end else begin
        sclk = ~sclk;
        mosi = mbit(k);
        repeat (8) @(negedge clk);
        if (miso !== exp_tx(k)) bad_s++;
        sclk = ~sclk;
        repeat (8) @(negedge clk);
      end
    end
    cs_n = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (done) begin
        dcnt++;
        tl = trans_len;
      end
    end
    nexp = (n < eff_len()) ? n : eff_len();
    if (rx_en) begin
      exp_rx = '0;
      for (int k = 0; k < nexp; k++) exp_rx[slot(k, rx_lsb)] = mbit(k);
    end else begin
      exp_rx = prev_rx;
    end
    chk(bad_s == 0, {"R3 R4 R8 R10 miso at sampling edge ", tag}, BB'(bad_s), '0);
    if (!cpha) chk(bad_m == 0, {"R9 miso mid-phase ", tag}, BB'(bad_m), '0);
    chk(rx_data === exp_rx, {"R1 R2 R7 rx buffer ", tag}, rx_data, exp_rx);
    chk(dcnt == 1, {"R6 done pulse count ", tag}, BB'(dcnt), BB'(1));
    chk(tl == LW'(nexp), {"R5 trans_len ", tag}, BB'(tl), BB'(nexp));
    chk(n == 0 || oe_seen, {"R11 oe during transaction ", tag}, BB'(oe_seen), BB'(1));
    chk(!miso_oe && !miso, {"R11 idle pad ", tag}, BB'({miso_oe, miso}), '0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    sclk = 1'b0; cs_n = 1'b1; mosi = 1'b0;
    mode = 2'd0; early = 1'b0; rx_lsb = 1'b0; tx_lsb = 1'b0;
    rx_en = 1'b1; tx_en = 1'b1; len = LW'(16);
    tx_load = 1'b0; tx_data = '0; tx_vec = '0; mvec = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R12: reset state
    chk(done == 1'b0 && trans_len == '0, "R12 done/trans_len after reset", BB'({done, trans_len}), '0);
    chk(rx_data == '0, "R12 rx_data after reset", rx_data, '0);
    chk(!miso_oe && !miso, "R12 R11 pad after reset", BB'({miso_oe, miso}), '0);

    // R1 R2 R3 R4 R5: sweep modes, bit orders, lengths, short/exact/long transfers
    for (int m = 0; m < 4; m++) begin
      for (int o = 0; o < 4; o++) begin
        for (int li = 0; li < 2; li++) begin
          for (int d = 0; d < 3; d++) begin
            int L, n;
            L = (li == 0) ? 5 : 16;
            n = (d == 0) ? L - 2 : (d == 1) ? L : L + 3;
            mode = 2'(m); rx_lsb = o[0]; tx_lsb = o[1]; len = LW'(L);
            set_pattern(m * 100 + o * 10 + li * 3 + d);
            load_tx(~mvec ^ {BB/32{32'h0F0F_3355}});
            set_pattern(m * 7 + o * 13 + li + d * 29);
            xfer(n, -1, $sformatf("m%0d o%0d L%0d n%0d", m, o, L, n));
          end
        end
      end
    end

    // R9: early launch in every mode (no effect for CPHA=1)
    rx_lsb = 1'b0; tx_lsb = 1'b1; len = LW'(16); early = 1'b1;
    for (int m = 0; m < 4; m++) begin
      mode = 2'(m);
      set_pattern(500 + m);
      load_tx(mvec ^ {BB/32{32'hA5A5_C3C3}});
      xfer(16, -1, $sformatf("early m%0d", m));
    end
    early = 1'b0;

    // R7: receive disabled leaves rx_data unchanged
    mode = 2'd1; rx_en = 1'b0;
    set_pattern(777);
    xfer(12, -1, "rx disabled");
    rx_en = 1'b1;

    // R8: transmit disabled sends zeros
    tx_en = 1'b0; mode = 2'd2;
    load_tx({BB/32{32'hFFFF_FFFF}});
    xfer(10, -1, "tx disabled");
    tx_en = 1'b1;

    // R10: load attempted mid-transaction is ignored, also in the next transaction
    mode = 2'd3; len = LW'(16);
    set_pattern(901);
    load_tx(mvec);
    xfer(16, 3, "load during transaction");
    xfer(16, -1, "after ignored load");

    // R4 R5: programmed length above the buffer clamps to 512
    mode = 2'd0; len = LW'(700);
    set_pattern(42);
    load_tx(~mvec);
    xfer(520, -1, "length above buffer");

    // R4 R5: zero length stores and sends nothing
    len = LW'(0);
    set_pattern(43);
    xfer(3, -1, "zero length");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule